// File: doc/BRIEF.md
# Serial Channel Modem-Status and Interrupt Register

This block gathers the status of a group of serial channels (sixteen by default) and turns it into one interrupt line. For each channel it shows the current levels of the four modem inputs, the receive-ready and receive-overrun indications, and a set of sticky flags. A flag is set whenever one of the modem inputs changes level, and one is set when the transmitter reports that it has drained. Each channel has three interrupt enables: one for modem changes, one for receive-ready and one for transmit-empty. Each channel's enabled causes are combined into one bit of a group status word.

A group mask word, where a set bit blocks a channel, and a group enable bit decide whether the interrupt line is driven. Software reads a channel's status word and writes the same value back. That write clears exactly the sticky flags it saw, and the live level bits ignore it. The modem inputs must already be synchronized to `clk`. The edge-detect history resets low.

Top module: `msr_irq_regs`

## Requirements
- R1: Channel status bits 0 (receive ready), 3 (DCD), 4 (DSR), 5 (CTS), 6 (RI) and 13 (overrun) follow their inputs in the same cycle, and a write to the status word leaves them unchanged.
- R2: A level change on DSR, CTS, DCD or RI sets status bit 16, 17, 18 or 22 respectively, visible in the cycle after the clock edge that samples the new level.
- R3: A one-cycle transmit-empty event pulse sets status bit 25 after the sampling edge.
- R4: Writing a 1 to a sticky bit (16, 17, 18, 22, 25) clears it and writing 0 leaves it set, so writing back a value just read clears only the flags that were seen.
- R5: When an input change and a write clearing the same flag arrive in the same cycle, the flag stays set.
- R6: Channel control bit 0 enables modem-change interrupts, bit 2 enables receive-ready and bit 19 enables transmit-empty. All other control bits read 0.
- R7: Group status bit c is 1 when channel c has a modem-change flag with bit 0 enabled, receive-ready with bit 2 enabled, or transmit-empty flag with bit 19 enabled.
- R8: After reset the group mask reads all ones (0x0000FFFF for 16 channels), and a set mask bit keeps its channel from driving the interrupt.
- R9: Group control bit 20 is the only writable bit of that word, resets to 0, and while it is 0 `irq_o` stays low.
- R10: `irq_o` is 1 exactly when bit 20 is set and some channel has its group status bit 1 and its mask bit 0.
- R11: Address map: with the top address bit 0, address bits [CH_W:1] pick the channel and bit 0 picks status (0) or control (1). With the top bit 1, low bits 0, 1 and 2 select group status (read-only), mask and group control, and 3 reads 0. For 16 channels these are 0x20, 0x21, 0x22 and 0x23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcd_i | input | NCH | Synchronized carrier-detect level per channel |
| dsr_i | input | NCH | Synchronized data-set-ready level per channel |
| cts_i | input | NCH | Synchronized clear-to-send level per channel |
| ri_i | input | NCH | Synchronized ring-indicator level per channel |
| rx_rdy_i | input | NCH | Receive data ready level per channel |
| rx_ovr_i | input | NCH | Receive overrun level per channel |
| txe_evt_i | input | NCH | Transmit-empty event pulse per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Group interrupt line |

## Verification
The assertions check on every cycle that the interrupt line is never high without the group enable and never high without an unmasked active channel. They also check that DSR edges always set their flag, that a flag only drops under a clearing write, that a clearing write with no edge does drop it, and that the mask starts as all ones. The bench's scenarios show the other behaviours. These are the full cross of cause and enable combinations per channel in the group status word, the read-only nature of the live bits, the tie between an edge and a clearing write, and the address decode of every register.

// File: rtl/msr_irq_pkg.sv
package msr_irq_pkg;
  localparam int WORD_W    = 32;
  // live level positions in the channel status word
  localparam int LV_RXRDY  = 0;
  localparam int LV_DCD    = 3;
  localparam int LV_DSR    = 4;
  localparam int LV_CTS    = 5;
  localparam int LV_RI     = 6;
  localparam int LV_OVR    = 13;
  // sticky flag positions
  localparam int ST_DSR    = 16;
  localparam int ST_CTS    = 17;
  localparam int ST_DCD    = 18;
  localparam int ST_RI     = 22;
  localparam int ST_TXE    = 25;
  // channel control enables
  localparam int CE_MSR    = 0;
  localparam int CE_RX     = 2;
  localparam int CE_TX     = 19;
  // group control enable
  localparam int GE_BIT    = 20;

  typedef enum logic [1:0] {
    GREG_STAT = 2'd0,
    GREG_MASK = 2'd1,
    GREG_CTRL = 2'd2,
    GREG_NONE = 2'd3
  } greg_e;

  // order of sticky clear bits handed to each channel
  typedef struct packed {
    logic txe;
    logic ri;
    logic dcd;
    logic cts;
    logic dsr;
  } clr_t;

  typedef struct packed {
    logic tx;
    logic rx;
    logic msr;
  } en_t;
endpackage

// File: rtl/chan_stat_unit.sv
module chan_stat_unit
  import msr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dcd,
  input  logic              line_dsr,
  input  logic              line_cts,
  input  logic              line_ri,
  input  logic              rx_rdy,
  input  logic              rx_ovr,
  input  logic              txe_evt,
  input  logic              stat_we,
  input  logic              ctrl_we,
  input  clr_t              clr_bits,
  input  en_t               en_bits,
  output logic [WORD_W-1:0] stat_word,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              cause
);
  // modem lines packed as {ri, dcd, cts, dsr}
  logic [3:0] cur_lv, prev_q, prev_d;
  logic [3:0] chg_q, chg_d, clr_chg, lv_edge;
  logic       txe_q, txe_d, clr_txe;
  en_t        en_q, en_d;

  always_comb begin
    cur_lv  = {line_ri, line_dcd, line_cts, line_dsr};
    lv_edge = cur_lv ^ prev_q;
    prev_d  = cur_lv;
    clr_chg = stat_we ? {clr_bits.ri, clr_bits.dcd, clr_bits.cts, clr_bits.dsr} : 4'b0;
    clr_txe = stat_we & clr_bits.txe;
    // a new edge wins over a simultaneous clear
    chg_d   = (chg_q & ~clr_chg) | lv_edge;
    txe_d   = (txe_q & ~clr_txe) | txe_evt;
    en_d    = ctrl_we ? en_bits : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      chg_q  <= '0;
      txe_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      chg_q  <= chg_d;
      txe_q  <= txe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ctrl_we) begin
      en_q <= en_d;
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[LV_RXRDY] = rx_rdy;
    stat_word[LV_DCD]   = line_dcd;
    stat_word[LV_DSR]   = line_dsr;
    stat_word[LV_CTS]   = line_cts;
    stat_word[LV_RI]    = line_ri;
    stat_word[LV_OVR]   = rx_ovr;
    stat_word[ST_DSR]   = chg_q[0];
    stat_word[ST_CTS]   = chg_q[1];
    stat_word[ST_DCD]   = chg_q[2];
    stat_word[ST_RI]    = chg_q[3];
    stat_word[ST_TXE]   = txe_q;

    ctrl_word           = '0;
    ctrl_word[CE_MSR]   = en_q.msr;
    ctrl_word[CE_RX]    = en_q.rx;
    ctrl_word[CE_TX]    = en_q.tx;

    cause = ((|chg_q) & en_q.msr) | (rx_rdy & en_q.rx) | (txe_q & en_q.tx);
  end
endmodule

// File: rtl/grp_irq_ctl.sv
module grp_irq_ctl #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cause,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_wdata,
  input  logic           ctrl_we,
  input  logic           en_wbit,
  output logic [NCH-1:0] grp_stat,
  output logic [NCH-1:0] grp_mask,
  output logic           grp_en,
  output logic           irq
);
  logic [NCH-1:0] mask_d;
  logic           en_d;

  always_comb begin
    mask_d   = mask_we ? mask_wdata : grp_mask;
    en_d     = ctrl_we ? en_wbit : grp_en;
    grp_stat = cause;
    irq      = grp_en & (|(cause & ~grp_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_mask <= '1;
    end else if (mask_we) begin
      grp_mask <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_en <= 1'b0;
    end else if (ctrl_we) begin
      grp_en <= en_d;
    end
  end
endmodule

// File: rtl/msr_irq_regs.sv
module msr_irq_regs
  import msr_irq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = $clog2(NCH) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    dcd_i,
  input  logic [NCH-1:0]    dsr_i,
  input  logic [NCH-1:0]    cts_i,
  input  logic [NCH-1:0]    ri_i,
  input  logic [NCH-1:0]    rx_rdy_i,
  input  logic [NCH-1:0]    rx_ovr_i,
  input  logic [NCH-1:0]    txe_evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int CH_W = $clog2(NCH);

  logic              is_grp, sel_ctrl;
  logic [CH_W-1:0]   ch_idx;
  greg_e             gsel;
  logic [NCH-1:0]    stat_we, ctrl_we, cause, dsr_chg;
  logic              gmask_we, gctrl_we;
  clr_t              clr_bits;
  en_t               en_bits;
  logic [WORD_W-1:0] stat_w [NCH];
  logic [WORD_W-1:0] ctrl_w [NCH];
  logic [NCH-1:0]    grp_stat, grp_mask;
  logic              grp_en;

  // address decode and write strobes
  always_comb begin
    is_grp   = reg_addr_i[ADDR_W-1];
    sel_ctrl = reg_addr_i[0];
    ch_idx   = reg_addr_i[CH_W:1];
    gsel     = greg_e'(reg_addr_i[1:0]);
    for (int c = 0; c < NCH; c++) begin
      stat_we[c] = reg_we_i && !is_grp && !sel_ctrl && (int'(ch_idx) == c);
      ctrl_we[c] = reg_we_i && !is_grp &&  sel_ctrl && (int'(ch_idx) == c);
    end
    gmask_we = reg_we_i && is_grp && (gsel == GREG_MASK);
    gctrl_we = reg_we_i && is_grp && (gsel == GREG_CTRL);
    clr_bits = '{txe: reg_wdata_i[ST_TXE], ri: reg_wdata_i[ST_RI],
                 dcd: reg_wdata_i[ST_DCD], cts: reg_wdata_i[ST_CTS],
                 dsr: reg_wdata_i[ST_DSR]};
    en_bits  = '{tx: reg_wdata_i[CE_TX], rx: reg_wdata_i[CE_RX],
                 msr: reg_wdata_i[CE_MSR]};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_stat_unit u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_dcd  (dcd_i[c]),
      .line_dsr  (dsr_i[c]),
      .line_cts  (cts_i[c]),
      .line_ri   (ri_i[c]),
      .rx_rdy    (rx_rdy_i[c]),
      .rx_ovr    (rx_ovr_i[c]),
      .txe_evt   (txe_evt_i[c]),
      .stat_we   (stat_we[c]),
      .ctrl_we   (ctrl_we[c]),
      .clr_bits  (clr_bits),
      .en_bits   (en_bits),
      .stat_word (stat_w[c]),
      .ctrl_word (ctrl_w[c]),
      .cause     (cause[c])
    );
    assign dsr_chg[c] = stat_w[c][ST_DSR];
  end

  grp_irq_ctl #(.NCH(NCH)) u_grp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cause      (cause),
    .mask_we    (gmask_we),
    .mask_wdata (reg_wdata_i[NCH-1:0]),
    .ctrl_we    (gctrl_we),
    .en_wbit    (reg_wdata_i[GE_BIT]),
    .grp_stat   (grp_stat),
    .grp_mask   (grp_mask),
    .grp_en     (grp_en),
    .irq        (irq_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (is_grp) begin
      unique case (gsel)
        GREG_STAT: reg_rdata_o[NCH-1:0] = grp_stat;
        GREG_MASK: reg_rdata_o[NCH-1:0] = grp_mask;
        GREG_CTRL: reg_rdata_o[GE_BIT]  = grp_en;
        default:   reg_rdata_o          = '0;
      endcase
    end else if (int'(ch_idx) < NCH) begin
      reg_rdata_o = sel_ctrl ? ctrl_w[ch_idx] : stat_w[ch_idx];
    end
  end
endmodule

// File: rtl/msr_irq_chk.sv
module msr_irq_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_o,
  input logic           grp_en,
  input logic [NCH-1:0] grp_mask,
  input logic [NCH-1:0] grp_stat,
  input logic [NCH-1:0] dsr_i,
  input logic [NCH-1:0] dsr_chg,
  input logic [NCH-1:0] stat_we,
  input logic           wclr_dsr
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_en |-> !irq_o); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(grp_stat & ~grp_mask)); // R10

  AST_MASK_STARTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (grp_mask == '1)); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_DSR_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (dsr_i[c] != $past(dsr_i[c]))) |=> dsr_chg[c]); // R2

    AST_DSR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_chg[c] && !(stat_we[c] && wclr_dsr)) |=> dsr_chg[c]); // R4

    AST_DSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && dsr_chg[c] && stat_we[c] && wclr_dsr && (dsr_i[c] == $past(dsr_i[c])))
        |=> !dsr_chg[c]); // R4
  end
endmodule

bind msr_irq_regs msr_irq_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_o    (irq_o),
  .grp_en   (grp_en),
  .grp_mask (grp_mask),
  .grp_stat (grp_stat),
  .dsr_i    (dsr_i),
  .dsr_chg  (dsr_chg),
  .stat_we  (stat_we),
  .wclr_dsr (reg_wdata_i[16])
);

// File: tb/msr_irq_regs_tb.sv
`timescale 1ns/1ps
module msr_irq_regs_tb;
  localparam int NCH = 16;
  localparam int AW  = 6;
  localparam logic [AW-1:0] A_GSTAT = 6'h20;
  localparam logic [AW-1:0] A_GMASK = 6'h21;
  localparam logic [AW-1:0] A_GCTRL = 6'h22;
  localparam logic [AW-1:0] A_GNONE = 6'h23;

  logic           clk, rst_n;
  logic [NCH-1:0] dcd, dsr, cts, ri, rxr, ovr, txe;
  logic           we;
  logic [AW-1:0]  addr;
  logic [31:0]    wdata, rdata;
  logic           irq;
  int             total, bad;
  logic [31:0]    v;

  msr_irq_regs #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .dcd_i(dcd), .dsr_i(dsr), .cts_i(cts), .ri_i(ri),
    .rx_rdy_i(rxr), .rx_ovr_i(ovr), .txe_evt_i(txe), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [AW-1:0] sa(int c); return AW'(c * 2); endfunction
  function automatic logic [AW-1:0] ca(int c); return AW'(c * 2 + 1); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  // k: 0 dcd, 1 dsr, 2 cts, 3 ri
  task automatic set_line(int c, int k, logic val);
    case (k)
      0: dcd[c] = val;
      1: dsr[c] = val;
      2: cts[c] = val;
      default: ri[c] = val;
    endcase
  endtask

  function automatic int live_pos(int k);
    case (k) 0: return 3; 1: return 4; 2: return 5; default: return 6; endcase
  endfunction
  function automatic int chg_pos(int k);
    case (k) 0: return 18; 1: return 16; 2: return 17; default: return 22; endcase
  endfunction

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    dcd = '0; dsr = '0; cts = '0; ri = '0; rxr = '0; ovr = '0; txe = '0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    rd(A_GMASK, v); chk("R8 mask after reset", v, 32'h0000FFFF);
    rd(A_GCTRL, v); chk("R9 group ctrl after reset", v, 32'h0);
    rd(A_GSTAT, v); chk("R7 group status after reset", v, 32'h0);
    rd(A_GNONE, v); chk("R11 unused group address", v, 32'h0);
    rd(sa(0), v);   chk("R1 status after reset", v, 32'h0);
    rd(ca(0), v);   chk("R6 control after reset", v, 32'h0);
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);

    // R1 R2 R4: every modem line of every channel
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 4; k++) begin
        tick(); set_line(c, k, 1'b1);
        tick();
        rd(sa(c), v); chk("R2 rise sets flag", v, (32'h1 << live_pos(k)) | (32'h1 << chg_pos(k)));
        wr(sa(c), 32'hFFFFFFFF);
        rd(sa(c), v); chk("R1 live bit survives write, R4 flag cleared", v, 32'h1 << live_pos(k));
        set_line(c, k, 1'b0);
        tick();
        rd(sa(c), v); chk("R2 fall sets flag", v, 32'h1 << chg_pos(k));
        wr(sa(c), 32'h0);
        rd(sa(c), v); chk("R4 zero write keeps flag", v, 32'h1 << chg_pos(k));
        wr(sa(c), v);
        rd(sa(c), v); chk("R4 write back clears", v, 32'h0);
      end
      rxr[c] = 1'b1; ovr[c] = 1'b1;
      #1; rd(sa(c), v); chk("R1 rx ready and overrun live", v, 32'h00002001);
      wr(sa(c), 32'hFFFFFFFF);
      rd(sa(c), v); chk("R1 rx live bits ignore write", v, 32'h00002001);
      rxr[c] = 1'b0; ovr[c] = 1'b0;
      #1; rd(sa(c), v); chk("R1 rx live bits drop", v, 32'h0);
    end

    // R3 transmit-empty event
    for (int c = 0; c < NCH; c += 5) begin
      tick(); txe[c] = 1'b1;
      tick(); txe[c] = 1'b0;
      rd(sa(c), v); chk("R3 tx empty flag", v, 32'h02000000);
      wr(sa(c), 32'h02000000);
      rd(sa(c), v); chk("R4 tx empty cleared", v, 32'h0);
    end

    // R5 edge and clearing write in the same cycle
    tick(); dsr[3] = 1'b1;
    tick();
    @(negedge clk); dsr[3] = 1'b0; we = 1'b1; addr = sa(3); wdata = 32'h00010000;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(sa(3), v); chk("R5 edge beats clear", v, 32'h00010000);
    wr(sa(3), v);
    rd(sa(3), v); chk("R5 later clear works", v, 32'h0);

    // R6 control word
    wr(ca(5), 32'hFFFFFFFF);
    rd(ca(5), v); chk("R6 only enable bits stick", v, 32'h00080005);
    rd(ca(4), v); chk("R11 neighbour control untouched", v, 32'h0);
    wr(ca(5), 32'h0);

    // R7 cause x enable sweep on every channel
    for (int c = 0; c < NCH; c++) begin
      for (int cz = 0; cz < 8; cz++) begin
        wr(sa(c), 32'hFFFFFFFF);
        rxr[c] = cz[1];
        if (cz[0]) cts[c] = ~cts[c];
        if (cz[2]) txe[c] = 1'b1;
        tick(); txe[c] = 1'b0;
        for (int en = 0; en < 8; en++) begin
          wr(ca(c), (en[0] ? 32'h1 : 32'h0) | (en[1] ? 32'h4 : 32'h0) | (en[2] ? 32'h80000 : 32'h0));
          rd(A_GSTAT, v);
          chk("R7 group status bit", v, ((cz & en) != 0) ? (32'h1 << c) : 32'h0);
        end
        chk("R9 irq low while disabled", {31'b0, irq}, 32'h0);
      end
      wr(ca(c), 32'h0);
      rxr[c] = 1'b0;
      wr(sa(c), 32'hFFFFFFFF);
    end

    // R8 R9 R10 interrupt line
    rxr = '1;
    for (int c = 0; c < NCH; c++) wr(ca(c), 32'h4);
    chk("R9 irq needs group enable", {31'b0, irq}, 32'h0);
    wr(A_GCTRL, 32'hFFFFFFFF);
    rd(A_GCTRL, v); chk("R9 only bit 20 writable", v, 32'h00100000);
    chk("R8 all masked keeps irq low", {31'b0, irq}, 32'h0);
    for (int c = 0; c < NCH; c++) begin
      wr(A_GMASK, ~(32'h1 << c));
      chk("R10 single unmasked channel drives irq", {31'b0, irq}, 32'h1);
      rxr[c] = 1'b0; #1;
      chk("R10 unmasked channel idle", {31'b0, irq}, 32'h0);
      rxr[c] = 1'b1;
    end
    wr(A_GMASK, 32'hFFFFFFFF);
    rd(A_GMASK, v); chk("R8 mask width", v, 32'h0000FFFF);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);
    wr(A_GMASK, 32'h0);
    chk("R10 unmasked irq high", {31'b0, irq}, 32'h1);
    wr(A_GCTRL, 32'h0);
    chk("R9 disable drops irq", {31'b0, irq}, 32'h0);
    rd(A_GSTAT, v); chk("R7 all channels active", v, 32'h0000FFFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule